// File: doc/BRIEF.md
# Token-Driven Column Exposure Loader

This block collects one 6-bit exposure value for each column of a passive-matrix display row. A single token marks the current write position. It enters from one of two token pins, and every shift clock moves it one position along the columns. At each step the data on the input bus is stored in the column, or in the red/green/blue column triplet, that holds the token. When the token steps past the final position, it leaves on the opposite token pin for one clock, so a neighbouring device in a chain can continue the load.

All writes land in a shadow bank. The active bank feeds the column drivers. It changes only on a rising latch-enable, and then takes the whole shadow bank in one step. This lets a complete row be loaded while the previous row is still being displayed. In narrow mode, one bus fills one column per clock. In wide mode, three buses fill an interleaved colour triplet per clock, so a load takes a third of the clocks.

Top module: `col_token_loader`

## Requirements
- R1: After reset both token outputs are low, the active bank is all zero, and the shadow bank is all zero, so a latch-enable with no load in between leaves the active bank zero.
- R2: Narrow mode (mode_i=0), right shift (dir_i=0): a high tok_l_i on an idle clock edge admits the token. Each of the next NUM_COLS edges stores bus_c_i into columns 0, 1, 2 and so on up to NUM_COLS-1, one column per edge.
- R3: Wide mode (mode_i=1), right shift: each of the NUM_COLS/3 edges after admission stores bus_a_i, bus_b_i and bus_c_i into columns 3t, 3t+1 and 3t+2, with t running from 0 upward.
- R4: Left shift (dir_i=1): the token is admitted from tok_r_i. Narrow loads fill columns from NUM_COLS-1 down to 0. Wide loads fill triplets from the last one down to triplet 0.
- R5: The clock after the last write, the exit pin is high for exactly one clock. The exit pin is tok_r_o for a right shift and tok_l_o for a left shift. The other token output stays low throughout.
- R6: Token inputs that arrive while a load is in progress are ignored. Once the token has left, bus data is not stored until a new token is admitted.
- R7: mode_i and dir_i are sampled when the token is admitted. Changing them during a load does not change which columns are written, which buses are used, or which pin the token exits on.
- R8: The active bank changes only on a rising edge of le_i, which copies the whole shadow bank. Holding le_i high copies once, and loads made while it stays high do not reach the active bank.
- R9: While idle, a token on the pin that is not the entry side for the current dir_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Shift direction: 0 right, 1 left |
| mode_i | input | 1 | Load mode: 0 narrow, 1 wide |
| tok_l_i | input | 1 | Token in on the left side |
| tok_r_i | input | 1 | Token in on the right side |
| tok_l_o | output | 1 | Token out on the left side |
| tok_r_o | output | 1 | Token out on the right side |
| bus_a_i | input | DW | Red data in wide mode |
| bus_b_i | input | DW | Green data in wide mode |
| bus_c_i | input | DW | Narrow data, or blue data in wide mode |
| le_i | input | 1 | Latch enable; a rising edge copies shadow to active |
| active_o | output | NUM_COLS*DW | Active bank; column c is at bits [c*DW +: DW] |

## Verification
The hardest case to reach is a wide left-shift load in which mode_i and dir_i are flipped, and both token inputs are pulsed, partway through the load. The stimulus sets up that load, inverts both controls at an early position, and raises both token pins a few positions later. It then checks that the token still exits on the left pin, and that every triplet holds the values expected for the mode and direction that were in force when the token entered. A second hard case is a full load made while latch-enable is held high. The stimulus raises le_i before the load and keeps it high throughout, and the bank contents are compared against the snapshot taken at the rising edge.

// File: rtl/col_loader_pkg.sv
package col_loader_pkg;
  typedef enum logic {LOAD_NARROW = 1'b0, LOAD_WIDE = 1'b1} load_mode_e;
  typedef enum logic {SHIFT_RIGHT = 1'b0, SHIFT_LEFT = 1'b1} shift_dir_e;
endpackage

// File: rtl/col_token_seq.sv
module col_token_seq
  import col_loader_pkg::*;
#(
  parameter int NUM_COLS = 240,
  localparam int NUM_TRIPS = NUM_COLS / 3,
  localparam int PW = $clog2(NUM_COLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_i,
  input  logic          mode_i,
  input  logic          tok_l_i,
  input  logic          tok_r_i,
  output logic          wr_en_o,
  output logic [PW-1:0] pos_o,
  output logic          wide_o,
  output logic          dir_o,
  output logic          tok_l_o,
  output logic          tok_r_o
);
  logic          busy_q, tok_out_q;
  logic [PW-1:0] pos_q, last_pos;
  load_mode_e    mode_q;
  shift_dir_e    dir_q;
  logic          tok_in, at_last;

  assign tok_in   = (shift_dir_e'(dir_i) == SHIFT_LEFT) ? tok_r_i : tok_l_i;
  assign last_pos = (mode_q == LOAD_WIDE) ? PW'(NUM_TRIPS - 1) : PW'(NUM_COLS - 1);
  assign at_last  = (pos_q == last_pos);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      pos_q     <= '0;
      mode_q    <= LOAD_NARROW;
      dir_q     <= SHIFT_RIGHT;
      tok_out_q <= 1'b0;
    end else begin
      tok_out_q <= busy_q && at_last;
      if (!busy_q) begin
        if (tok_in) begin
          // controls frozen for the whole load
          busy_q <= 1'b1;
          pos_q  <= '0;
          mode_q <= load_mode_e'(mode_i);
          dir_q  <= shift_dir_e'(dir_i);
        end
      end else if (at_last) begin
        busy_q <= 1'b0;
        pos_q  <= '0;
      end else begin
        pos_q <= pos_q + PW'(1);
      end
    end
  end

  assign wr_en_o = busy_q;
  assign pos_o   = pos_q;
  assign wide_o  = (mode_q == LOAD_WIDE);
  assign dir_o   = (dir_q == SHIFT_LEFT);
  assign tok_r_o = tok_out_q && (dir_q == SHIFT_RIGHT);
  assign tok_l_o = tok_out_q && (dir_q == SHIFT_LEFT);

  p_pos_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (pos_q <= last_pos));
  p_exit_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_out_q |=> !tok_out_q);
  p_exit_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_out_q |-> !busy_q);
  p_ctrl_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !at_last) |=> ($stable(mode_q) && $stable(dir_q)));
endmodule

// File: rtl/col_shadow_bank.sv
module col_shadow_bank #(
  parameter int NUM_COLS = 240,
  parameter int DW = 6,
  localparam int NUM_TRIPS = NUM_COLS / 3,
  localparam int PW = $clog2(NUM_COLS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [PW-1:0]          pos_i,
  input  logic                   wide_i,
  input  logic                   dir_i,
  input  logic [DW-1:0]          bus_a_i,
  input  logic [DW-1:0]          bus_b_i,
  input  logic [DW-1:0]          bus_c_i,
  output logic [NUM_COLS*DW-1:0] shadow_o
);
  logic [PW-1:0] col_sel, trip_sel;

  assign col_sel  = dir_i ? (PW'(NUM_COLS - 1) - pos_i) : pos_i;
  assign trip_sel = dir_i ? (PW'(NUM_TRIPS - 1) - pos_i) : pos_i;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    localparam int TRIP = c / 3;
    localparam int LANE = c % 3;
    logic [DW-1:0] lane_d, wr_d, val_q;
    logic          hit;

    if (LANE == 0) begin : g_red
      assign lane_d = bus_a_i;
    end else if (LANE == 1) begin : g_grn
      assign lane_d = bus_b_i;
    end else begin : g_blu
      assign lane_d = bus_c_i;
    end

    assign hit  = wr_en_i && (wide_i ? (trip_sel == PW'(TRIP)) : (col_sel == PW'(c)));
    assign wr_d = wide_i ? lane_d : bus_c_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  val_q <= '0;
      else if (hit) val_q <= wr_d;
    end

    assign shadow_o[c*DW +: DW] = val_q;
  end

  p_trip_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wide_i) |-> (trip_sel < PW'(NUM_TRIPS)));
  p_col_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wide_i) |-> (col_sel < PW'(NUM_COLS)));
endmodule

// File: rtl/col_active_bank.sv
module col_active_bank #(
  parameter int NUM_COLS = 240,
  parameter int DW = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   le_i,
  input  logic [NUM_COLS*DW-1:0] shadow_i,
  output logic [NUM_COLS*DW-1:0] active_o
);
  logic                   le_q;
  logic [NUM_COLS*DW-1:0] active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      le_q     <= 1'b0;
      active_q <= '0;
    end else begin
      le_q <= le_i;
      if (le_i && !le_q) active_q <= shadow_i;
    end
  end

  assign active_o = active_q;

  p_active_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(le_i && !le_q) |=> $stable(active_q));
  p_active_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_i && !le_q) |=> (active_q == $past(shadow_i)));
endmodule

// File: rtl/col_token_loader.sv
module col_token_loader
  import col_loader_pkg::*;
#(
  parameter int NUM_COLS = 240,
  parameter int DW = 6,
  localparam int PW = $clog2(NUM_COLS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   dir_i,
  input  logic                   mode_i,
  input  logic                   tok_l_i,
  input  logic                   tok_r_i,
  output logic                   tok_l_o,
  output logic                   tok_r_o,
  input  logic [DW-1:0]          bus_a_i,
  input  logic [DW-1:0]          bus_b_i,
  input  logic [DW-1:0]          bus_c_i,
  input  logic                   le_i,
  output logic [NUM_COLS*DW-1:0] active_o
);
  logic                   wr_en, wide, dir_l;
  logic [PW-1:0]          pos;
  logic [NUM_COLS*DW-1:0] shadow;

  col_token_seq #(.NUM_COLS(NUM_COLS)) u_seq (
    .clk_i, .rst_ni, .dir_i, .mode_i, .tok_l_i, .tok_r_i,
    .wr_en_o(wr_en), .pos_o(pos), .wide_o(wide), .dir_o(dir_l),
    .tok_l_o, .tok_r_o
  );

  col_shadow_bank #(.NUM_COLS(NUM_COLS), .DW(DW)) u_shadow (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .pos_i(pos), .wide_i(wide), .dir_i(dir_l),
    .bus_a_i, .bus_b_i, .bus_c_i, .shadow_o(shadow)
  );

  col_active_bank #(.NUM_COLS(NUM_COLS), .DW(DW)) u_active (
    .clk_i, .rst_ni, .le_i, .shadow_i(shadow), .active_o
  );

  p_exit_exclusive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tok_l_o, tok_r_o}));
endmodule

// File: tb/tb_col_token_loader.sv
module tb_col_token_loader;
  localparam int N  = 240;
  localparam int DW = 6;
  localparam int T  = N / 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic dir_i = 1'b0, mode_i = 1'b0, tok_l_i = 1'b0, tok_r_i = 1'b0, le_i = 1'b0;
  logic [DW-1:0] bus_a_i = '0, bus_b_i = '0, bus_c_i = '0;
  logic tok_l_o, tok_r_o;
  logic [N*DW-1:0] active_o;

  logic [DW-1:0] exp_sh [N];
  logic [DW-1:0] exp_act[N];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  col_token_loader #(.NUM_COLS(N), .DW(DW)) dut (
    .clk_i(clk), .rst_ni, .dir_i, .mode_i, .tok_l_i, .tok_r_i,
    .tok_l_o, .tok_r_o, .bus_a_i, .bus_b_i, .bus_c_i, .le_i, .active_o
  );

  function automatic logic [DW-1:0] pat(int i, int seed, int lane);
    return DW'((i * 7 + seed * 11 + lane * 13 + 5) % 64);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_bank(string req, string what);
    int bad = -1;
    for (int c = 0; c < N; c++)
      if (bad < 0 && active_o[c*DW +: DW] !== exp_act[c]) bad = c;
    if (bad < 0) chk(1'b1, req, what, 0, 0);
    else chk(1'b0, req, $sformatf("%s col %0d", what, bad),
             int'(active_o[bad*DW +: DW]), int'(exp_act[bad]));
  endtask

  task automatic pulse_le(string req, string what);
    @(negedge clk); le_i = 1'b1;
    @(negedge clk); le_i = 1'b0;
    for (int c = 0; c < N; c++) exp_act[c] = exp_sh[c];
    check_bank(req, what);
  endtask

  // token in, full load, exit pulse; optional mid-load control flip and token poke
  task automatic run_load(logic d, logic w, int seed, bit flip, bit poke, string req);
    int len = w ? T : N;
    bit quiet = 1'b1;
    @(negedge clk);
    dir_i = d; mode_i = w;
    if (d) tok_r_i = 1'b1; else tok_l_i = 1'b1;
    @(negedge clk);
    tok_l_i = 1'b0; tok_r_i = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (flip && i == 5) begin dir_i = ~d; mode_i = ~w; end
      if (poke && i == 10) begin tok_l_i = 1'b1; tok_r_i = 1'b1; end
      if (poke && i == 11) begin tok_l_i = 1'b0; tok_r_i = 1'b0; end
      bus_a_i = pat(i, seed, 0);
      bus_b_i = pat(i, seed, 1);
      bus_c_i = pat(i, seed, 2);
      if (w) begin
        int t = d ? (T - 1 - i) : i;
        exp_sh[3*t]   = bus_a_i;
        exp_sh[3*t+1] = bus_b_i;
        exp_sh[3*t+2] = bus_c_i;
      end else begin
        exp_sh[d ? (N - 1 - i) : i] = bus_c_i;
      end
      @(negedge clk);
      if (i < len - 1 && (tok_l_o || tok_r_o)) quiet = 1'b0;
    end
    chk(quiet, "R5", {req, " no token out during load"}, int'(quiet), 1);
    chk((d ? tok_l_o : tok_r_o) === 1'b1, "R5", {req, " exit pin high"},
        int'(d ? tok_l_o : tok_r_o), 1);
    chk((d ? tok_r_o : tok_l_o) === 1'b0, "R5", {req, " other pin low"},
        int'(d ? tok_r_o : tok_l_o), 0);
    @(negedge clk);
    chk({tok_l_o, tok_r_o} === 2'b00, "R5", {req, " exit one clock"},
        int'({tok_l_o, tok_r_o}), 0);
    dir_i = d; mode_i = w;
  endtask

  task automatic t_reset();
    for (int c = 0; c < N; c++) begin exp_sh[c] = '0; exp_act[c] = '0; end
    chk({tok_l_o, tok_r_o} === 2'b00, "R1", "token outs after reset",
        int'({tok_l_o, tok_r_o}), 0);
    check_bank("R1", "active zero after reset");
    pulse_le("R1", "shadow zero after reset");
  endtask

  task automatic t_narrow_right();
    run_load(1'b0, 1'b0, 1, 1'b0, 1'b0, "R2");
    check_bank("R8", "active unchanged before latch");
    pulse_le("R2", "narrow right contents");
  endtask

  task automatic t_narrow_left();
    run_load(1'b1, 1'b0, 2, 1'b0, 1'b0, "R4");
    pulse_le("R4", "narrow left contents");
  endtask

  task automatic t_wide_right();
    run_load(1'b0, 1'b1, 3, 1'b0, 1'b0, "R3");
    pulse_le("R3", "wide right contents");
  endtask

  task automatic t_wide_left_disturbed();
    run_load(1'b1, 1'b1, 4, 1'b1, 1'b1, "R7");
    pulse_le("R7", "wide left with mid-load flip and poke (R6)");
  endtask

  task automatic t_idle_ignore();
    bit quiet = 1'b1;
    @(negedge clk);
    dir_i = 1'b0; mode_i = 1'b0;
    tok_r_i = 1'b1;  // wrong side for a right shift
    for (int i = 0; i < 20; i++) begin
      bus_a_i = pat(i, 9, 0); bus_b_i = pat(i, 9, 1); bus_c_i = pat(i, 9, 2);
      @(negedge clk);
      tok_r_i = 1'b0;
      if (tok_l_o || tok_r_o) quiet = 1'b0;
    end
    chk(quiet, "R9", "no token out for wrong-side token", int'(quiet), 1);
    pulse_le("R6", "idle bus data not stored (R9)");
  endtask

  task automatic t_le_held();
    @(negedge clk); le_i = 1'b1;
    @(negedge clk);
    for (int c = 0; c < N; c++) exp_act[c] = exp_sh[c];
    run_load(1'b0, 1'b0, 6, 1'b0, 1'b0, "R8");
    check_bank("R8", "held latch-enable copies once");
    le_i = 1'b0;
    pulse_le("R8", "fresh rise copies new load");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow_right();
    t_narrow_left();
    t_wide_right();
    t_wide_left_disturbed();
    t_idle_ignore();
    t_le_held();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule